// File: doc/BRIEF.md
# GPIO Output-Enable Set/Clear Register Bank

This block keeps one output-enable bit per general-purpose pin and drives the final output-enable of each pad. Software reaches it over a simple memory-mapped register bus. A write-one-to-set register turns drivers on. A write-one-to-clear register turns them off. A read-only status register reports the stored bits, where a 1 means the pin is an output.

Each pin also has an ownership select. While the GPIO logic owns a pin, the stored enable drives that pad. While an on-chip peripheral owns it, the peripheral's own enable drives the pad. Writes to a peripheral-owned pin still update the stored bit, so the stored bit takes effect at once when ownership returns to GPIO.

Top module: `gpio_oe_bank`

## Requirements
- R1: A write to offset 0x10 sets every stored enable bit whose write-data bit is 1. Bits written 0 keep their value.
- R2: A write to offset 0x14 clears every stored enable bit whose write-data bit is 1. Bits written 0 keep their value.
- R3: A read of offset 0x18 returns the stored enable bits, with 1 meaning output and 0 meaning input. These bits are the combined result of all earlier set and clear writes.
- R4: After reset every stored enable bit is 0. A reset asserted in mid-operation returns the status to 0.
- R5: Set and clear writes update the stored bit of a peripheral-owned pin without changing that pin's pad enable.
- R6: When own_gpio[n] is 1, pad_oe[n] equals stored bit n. When own_gpio[n] is 0, pad_oe[n] equals periph_oe[n].
- R7: Reads of offsets 0x10, 0x14 or any unmapped offset return 0. Writes to offset 0x18 or to an unmapped offset change no stored bit.
- R8: A write takes effect on the rising clock edge of its bus cycle, and a read in any later cycle shows the new value.
- R9: Bit n of the write data, the read data, own_gpio, periph_oe and pad_oe belongs to pin n, for n from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| own_gpio | input | 32 | Per-pin ownership: 1 means GPIO, 0 means peripheral |
| periph_oe | input | 32 | Output enables from the peripherals |
| pad_oe | output | 32 | Final output enable for each pad |

## Verification
A wrong stored bit appears on the status read in the cycle right after the write that caused it. For a GPIO-owned pin it also appears on pad_oe from that same clock edge. For a peripheral-owned pin a bad bit stays hidden at the pad. It only shows at the pad once ownership returns to GPIO, so the bench checks those pins through the status read and then by switching ownership back. A decode fault shows as a status that changed after a write to the wrong offset, or as nonzero data read from a write-only offset.

// File: rtl/gpio_oe_bank.sv
module gpio_oe_bank #(
  parameter int W = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_SET = 8'h10,
  parameter logic [AW-1:0] OFS_CLR = 8'h14,
  parameter logic [AW-1:0] OFS_STAT = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  own_gpio,
  input  logic [W-1:0]  periph_oe,
  output logic [W-1:0]  pad_oe
);
  logic [W-1:0] oe_q;
  logic wr_set, wr_clr, rd_stat;

  assign wr_set  = bus_req && bus_wr && (bus_addr == OFS_SET);
  assign wr_clr  = bus_req && bus_wr && (bus_addr == OFS_CLR);
  assign rd_stat = bus_req && !bus_wr && (bus_addr == OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      oe_q <= '0;
    else if (wr_set)
      oe_q <= oe_q | bus_wdata;
    else if (wr_clr)
      oe_q <= oe_q & ~bus_wdata;
  end

  assign bus_rdata = rd_stat ? oe_q : '0;
  assign pad_oe = (own_gpio & oe_q) | (~own_gpio & periph_oe);
endmodule

// File: rtl/gpio_oe_bank_chk.sv
module gpio_oe_bank_chk #(
  parameter int W = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_SET = 8'h10,
  parameter logic [AW-1:0] OFS_CLR = 8'h14,
  parameter logic [AW-1:0] OFS_STAT = 8'h18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  own_gpio,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  oe_q
);
  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == OFS_SET) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == OFS_CLR) |=> ((oe_q & $past(bus_wdata)) == '0));

  p_stat_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_addr == OFS_STAT) |-> (bus_rdata == oe_q));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_wr && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |=> $stable(oe_q));

  p_wo_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_addr != OFS_STAT) |-> (bus_rdata == '0));

  p_gpio_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ oe_q) & own_gpio) == '0);
endmodule

bind gpio_oe_bank gpio_oe_bank_chk #(
  .W(W), .AW(AW), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR), .OFS_STAT(OFS_STAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .own_gpio(own_gpio), .pad_oe(pad_oe), .oe_q(oe_q)
);

// File: tb/gpio_oe_bank_test.sv
module gpio_oe_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam logic [7:0] A_SET = 8'h10, A_CLR = 8'h14, A_STAT = 8'h18;

  // {addr, wdata, expected status after the write}
  localparam logic [71:0] VEC [NV] = '{
    {A_SET,  32'hFFFF0000, 32'hFFFF0000},
    {A_CLR,  32'h0F0F0000, 32'hF0F00000},
    {A_SET,  32'h0000000F, 32'hF0F0000F},
    {A_CLR,  32'h00000000, 32'hF0F0000F},
    {A_SET,  32'h00000100, 32'hF0F0010F},
    {A_CLR,  32'h80000001, 32'h70F0010E},
    {A_STAT, 32'hFFFFFFFF, 32'h70F0010E},
    {A_CLR,  32'hFFFFFFFF, 32'h00000000},
    {8'h1C,  32'h55AA55AA, 32'h00000000},
    {A_SET,  32'hA5A5A5A5, 32'hA5A5A5A5}
  };

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] own_gpio = '1, periph_oe = 0, pad_oe;
  int checks = 0, fails = 0;

  gpio_oe_bank uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_req = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R4 pad_oe in reset", pad_oe, 32'h0);
    rst_n = 1;
    rd(A_STAT, r); chk("R4 status after reset", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      chk("R1/R2/R8 pad_oe after write", pad_oe, VEC[i][31:0]);
      rd(A_STAT, r);
      chk("R3 R9 status after write", r, VEC[i][31:0]);
    end

    rd(A_SET, r); chk("R7 read of set register", r, 32'h0);
    rd(A_CLR, r); chk("R7 read of clear register", r, 32'h0);

    own_gpio = 32'h0000FFFF; periph_oe = 32'h12345678;
    #1 chk("R6 mixed ownership", pad_oe, 32'h1234A5A5);
    wr(A_CLR, 32'hFFFFFFFF);
    chk("R5 clear keeps peripheral pins", pad_oe, 32'h12340000);
    rd(A_STAT, r); chk("R5 stored bits cleared", r, 32'h0);

    own_gpio = 32'h0; periph_oe = 32'h0;
    wr(A_SET, 32'h00000003);
    chk("R5 set on peripheral pins hidden", pad_oe, 32'h0);
    rd(A_STAT, r); chk("R5 set stored while peripheral owns", r, 32'h3);
    own_gpio = 32'hFFFFFFFF;
    #1 chk("R6 stored bits reach pads on GPIO ownership", pad_oe, 32'h3);

    wr(A_SET, 32'h80000000);
    rd(A_STAT, r); chk("R9 top pin maps to bit 31", r, 32'h80000003);

    @(negedge clk); rst_n = 0;
    #1 chk("R4 pad_oe cleared by reset", pad_oe, 32'h0);
    @(negedge clk); rst_n = 1;
    rd(A_STAT, r); chk("R4 status cleared by reset", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule